// File: doc/BRIEF.md
# Breakpoint Comparator Bank

This block keeps a small set of programmable execution breakpoint slots. It compares the address of every instruction that the core retires or skips against all of them in parallel. Each slot holds a base address, a second operand called the bound, a 4-bit compare kind and a flag that makes the slot conditional. When a live slot matches, the block raises a halt request for one cycle and gives the handle of the slot that matched. The handle is the slot index.

A command port installs and removes slots. A set command places the breakpoint in the lowest free slot. If a live slot already holds the same base address, the set command reuses that slot instead. A set command can also be marked as a dry run: it then only reports whether a free slot exists and changes nothing. A clear command removes the slot named by its handle. Every command gets a one-cycle response carrying a status byte and a handle. The status codes are 0 for success, 142 for "no breakpoint resources left" and 145 for "no such breakpoint". Decoding the messages and halting the core are done elsewhere.

Top module: `bp_bank`

## Requirements
- R1: Kinds 0 to 4 compare the instruction address with the base as unsigned 32-bit values. Kind 0 matches when they are equal, kind 1 when the address is greater, kind 2 when it is greater or equal, kind 3 when it is less, and kind 4 when it is less or equal.
- R2: Kind 5 matches when base <= address <= bound. Kind 6 matches in every other case.
- R3: Kind 7 matches when (address AND bound) equals the base.
- R4: Kinds 8 to 15 are stored when set, but they never match.
- R5: A slot with the conditional flag set matches only when `ins_executed` is 1. A slot without the flag also matches a skipped instruction (`ins_executed` = 0).
- R6: A set command (`cmd_clear`=0, `cmd_dry`=0) with no live slot at the same base takes the lowest-index free slot. It returns that index as the handle. The response (`rsp_valid`, status, handle) appears exactly one cycle after `cmd_valid`, and only then.
- R7: A set command returns status 142 when it fills the last free slot, and the breakpoint is still installed. A set command that finds no free slot and no slot at the same base returns status 142 and handle 0, and it changes no slot.
- R8: A dry-run set (`cmd_dry`=1) changes no slot. It returns status 0 and the lowest free index when a slot is free. Otherwise it returns status 142.
- R9: A set command whose base equals the base of a live slot replaces that slot, with the same handle, and the new kind and flag take effect. Status is 0, or 142 if no free slot remains.
- R10: A clear command (`cmd_clear`=1) on a live handle frees that slot and returns status 0. On a handle that is not live it returns status 145 and changes nothing.
- R11: `halt_req` is 1 exactly one cycle after a cycle with `ins_valid`=1 in which at least one live slot matched. `halt_handle` then holds the lowest matching index.
- R12: After reset all slots are free, and `rsp_valid` and `halt_req` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_clear | input | 1 | 1 = clear command, 0 = set command |
| cmd_dry | input | 1 | Dry-run qualifier for set commands |
| cmd_addr | input | 32 | Base address of a set |
| cmd_bound | input | 32 | Bound or mask of a set |
| cmd_kind | input | 4 | Compare kind of a set |
| cmd_cond | input | 1 | Conditional flag of a set |
| cmd_handle | input | 2 | Slot handle of a clear |
| rsp_valid | output | 1 | Response strobe |
| rsp_status | output | 8 | Response status code |
| rsp_handle | output | 2 | Response slot handle |
| ins_valid | input | 1 | An instruction reached its address this cycle |
| ins_pc | input | 32 | Address of that instruction |
| ins_executed | input | 1 | 1 = instruction executed, 0 = condition failed |
| halt_req | output | 1 | Halt request |
| halt_handle | output | 2 | Handle of the matching slot |

## Verification
The hardest cases to reach are the ones that depend on bank occupancy: the last free slot being taken, a completely full bank, and replacement at the same base. Each needs a specific history of set and clear commands. The stimulus first fills every slot and checks the 142 status on the final fill. It then tries a fifth set and a dry run against the full bank, probing the rejected address to show that nothing was installed. Next it frees one middle slot and confirms that a dry run reports that slot without taking it. Replacement is shown by re-setting an existing base with the conditional flag. The slot count stays the same, and a skipped instruction at that base no longer halts.

// File: rtl/bp_pkg.sv
package bp_pkg;
  localparam int unsigned BP_STW = 8;
  localparam logic [BP_STW-1:0] BP_ST_OK       = 8'd0;
  localparam logic [BP_STW-1:0] BP_ST_NO_ROOM  = 8'd142;
  localparam logic [BP_STW-1:0] BP_ST_NO_SUCH  = 8'd145;

  typedef enum logic [3:0] {
    K_EQ   = 4'd0,
    K_GT   = 4'd1,
    K_GE   = 4'd2,
    K_LT   = 4'd3,
    K_LE   = 4'd4,
    K_IN   = 4'd5,
    K_OUT  = 4'd6,
    K_MASK = 4'd7
  } bp_kind_e;
endpackage

// File: rtl/bp_lowest.sv
module bp_lowest #(
  parameter int unsigned N  = 4,
  parameter int unsigned IW = 2
) (
  input  logic [N-1:0]  req,
  output logic          found,
  output logic [IW-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        found = 1'b1;
        idx   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/bp_cmp.sv
module bp_cmp
  import bp_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  logic [3:0]    kind,
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] bound,
  input  logic [AW-1:0] pc,
  output logic          hit
);
  logic in_rng;

  always_comb begin
    in_rng = (pc >= base) && (pc <= bound);
    case (kind)
      K_EQ:    hit = (pc == base);
      K_GT:    hit = (pc > base);
      K_GE:    hit = (pc >= base);
      K_LT:    hit = (pc < base);
      K_LE:    hit = (pc <= base);
      K_IN:    hit = in_rng;
      K_OUT:   hit = !in_rng;
      K_MASK:  hit = ((pc & bound) == base);
      default: hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/bp_bank.sv
module bp_bank
  import bp_pkg::*;
#(
  parameter int unsigned NUM_SLOTS = 4,
  parameter int unsigned AW        = 32,
  localparam int unsigned HW       = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic              cmd_clear,
  input  logic              cmd_dry,
  input  logic [AW-1:0]     cmd_addr,
  input  logic [AW-1:0]     cmd_bound,
  input  logic [3:0]        cmd_kind,
  input  logic              cmd_cond,
  input  logic [HW-1:0]     cmd_handle,
  output logic              rsp_valid,
  output logic [BP_STW-1:0] rsp_status,
  output logic [HW-1:0]     rsp_handle,
  input  logic              ins_valid,
  input  logic [AW-1:0]     ins_pc,
  input  logic              ins_executed,
  output logic              halt_req,
  output logic [HW-1:0]     halt_handle
);
  // slot storage
  logic [NUM_SLOTS-1:0] slot_vld_q, slot_vld_d;
  logic [AW-1:0]        slot_lo_q   [NUM_SLOTS];
  logic [AW-1:0]        slot_hi_q   [NUM_SLOTS];
  logic [3:0]           slot_kind_q [NUM_SLOTS];
  logic [NUM_SLOTS-1:0] slot_cond_q;

  logic [NUM_SLOTS-1:0] free_vec, same_vec, cmp_vec, hit_vec, free_after;
  logic                 free_any, same_any, hit_any;
  logic [HW-1:0]        free_idx, same_idx, hit_idx;

  logic                 wr_en;
  logic [HW-1:0]        wr_idx;
  logic [BP_STW-1:0]    st_d;
  logic [HW-1:0]        hd_d;

  // per-slot comparators and qualification
  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    bp_cmp #(.AW(AW)) i_cmp (
      .kind  (slot_kind_q[g]),
      .base  (slot_lo_q[g]),
      .bound (slot_hi_q[g]),
      .pc    (ins_pc),
      .hit   (cmp_vec[g])
    );
    assign free_vec[g] = !slot_vld_q[g];
    assign same_vec[g] = slot_vld_q[g] && (slot_lo_q[g] == cmd_addr);
    assign hit_vec[g]  = ins_valid && slot_vld_q[g] && cmp_vec[g] &&
                         (!slot_cond_q[g] || ins_executed);
  end

  bp_lowest #(.N(NUM_SLOTS), .IW(HW)) i_pick_free (
    .req(free_vec), .found(free_any), .idx(free_idx));
  bp_lowest #(.N(NUM_SLOTS), .IW(HW)) i_pick_same (
    .req(same_vec), .found(same_any), .idx(same_idx));
  bp_lowest #(.N(NUM_SLOTS), .IW(HW)) i_pick_hit (
    .req(hit_vec), .found(hit_any), .idx(hit_idx));

  // command decode, next state
  always_comb begin
    slot_vld_d = slot_vld_q;
    wr_en      = 1'b0;
    wr_idx     = '0;
    st_d       = BP_ST_OK;
    hd_d       = '0;
    free_after = free_vec;
    if (cmd_valid) begin
      if (cmd_clear) begin
        hd_d = cmd_handle;
        if (({1'b0, cmd_handle} < (HW+1)'(NUM_SLOTS)) && slot_vld_q[cmd_handle]) begin
          slot_vld_d[cmd_handle] = 1'b0;
        end else begin
          st_d = BP_ST_NO_SUCH;
        end
      end else if (cmd_dry) begin
        hd_d = free_idx;
        st_d = free_any ? BP_ST_OK : BP_ST_NO_ROOM;
      end else if (same_any || free_any) begin
        wr_en  = 1'b1;
        wr_idx = same_any ? same_idx : free_idx;
        hd_d   = wr_idx;
        slot_vld_d[wr_idx] = 1'b1;
        free_after[wr_idx] = 1'b0;
        st_d   = (|free_after) ? BP_ST_OK : BP_ST_NO_ROOM;
      end else begin
        st_d = BP_ST_NO_ROOM;
      end
    end
  end

  // control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_vld_q  <= '0;
      rsp_valid   <= 1'b0;
      rsp_status  <= '0;
      rsp_handle  <= '0;
      halt_req    <= 1'b0;
      halt_handle <= '0;
    end else begin
      slot_vld_q <= slot_vld_d;
      rsp_valid  <= cmd_valid;
      if (cmd_valid) begin
        rsp_status <= st_d;
        rsp_handle <= hd_d;
      end
      halt_req <= hit_any;
      if (hit_any) begin
        halt_handle <= hit_idx;
      end
    end
  end

  // slot payload, write-enabled, no reset needed
  always_ff @(posedge clk) begin
    if (wr_en) begin
      slot_lo_q[wr_idx]   <= cmd_addr;
      slot_hi_q[wr_idx]   <= cmd_bound;
      slot_kind_q[wr_idx] <= cmd_kind;
      slot_cond_q[wr_idx] <= cmd_cond;
    end
  end
endmodule

// File: rtl/bp_bank_chk.sv
module bp_bank_chk #(
  parameter int unsigned NUM_SLOTS = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 cmd_valid,
  input logic                 cmd_clear,
  input logic                 cmd_dry,
  input logic                 rsp_valid,
  input logic [7:0]           rsp_status,
  input logic                 ins_valid,
  input logic                 halt_req,
  input logic [NUM_SLOTS-1:0] slot_vld
);
  AST_RSP_FOLLOWS_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> rsp_valid); // R6
  AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |=> !rsp_valid); // R6
  AST_IDLE_KEEPS_SLOTS: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |=> $stable(slot_vld)); // R6
  AST_DRY_KEEPS_SLOTS: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_clear && cmd_dry) |=> $stable(slot_vld)); // R8
  AST_CLEAR_NEVER_ADDS: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_clear) |=> ($countones(slot_vld) <= $countones($past(slot_vld)))); // R10
  AST_SET_ADDS_AT_MOST_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_clear && !cmd_dry) |=>
      ($countones(slot_vld) <= $countones($past(slot_vld)) + 1)); // R9
  AST_NO_SUCH_FROM_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_status == 8'd145) |-> $past(cmd_clear)); // R10
  AST_HALT_NEEDS_INS: assert property (@(posedge clk) disable iff (!rst_n)
    !ins_valid |=> !halt_req); // R11
endmodule

bind bp_bank bp_bank_chk #(.NUM_SLOTS(NUM_SLOTS)) i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cmd_valid  (cmd_valid),
  .cmd_clear  (cmd_clear),
  .cmd_dry    (cmd_dry),
  .rsp_valid  (rsp_valid),
  .rsp_status (rsp_status),
  .ins_valid  (ins_valid),
  .halt_req   (halt_req),
  .slot_vld   (slot_vld_q)
);

// File: tb/test_bp_bank.sv
`timescale 1ns/1ps
module test_bp_bank;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cmd_valid, cmd_clear, cmd_dry, cmd_cond;
  logic [31:0] cmd_addr, cmd_bound;
  logic [3:0]  cmd_kind;
  logic [1:0]  cmd_handle;
  logic        rsp_valid;
  logic [7:0]  rsp_status;
  logic [1:0]  rsp_handle;
  logic        ins_valid, ins_executed;
  logic [31:0] ins_pc;
  logic        halt_req;
  logic [1:0]  halt_handle;

  int n_tests = 0;
  int n_fail  = 0;

  always #2.5 clk = ~clk;

  bp_bank #(.NUM_SLOTS(4), .AW(32)) i_bp_bank (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_clear(cmd_clear), .cmd_dry(cmd_dry),
    .cmd_addr(cmd_addr), .cmd_bound(cmd_bound), .cmd_kind(cmd_kind),
    .cmd_cond(cmd_cond), .cmd_handle(cmd_handle),
    .rsp_valid(rsp_valid), .rsp_status(rsp_status), .rsp_handle(rsp_handle),
    .ins_valid(ins_valid), .ins_pc(ins_pc), .ins_executed(ins_executed),
    .halt_req(halt_req), .halt_handle(halt_handle)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cmd(input logic clr, input logic dry, input logic [31:0] a,
                     input logic [31:0] b, input logic [3:0] k, input logic c,
                     input logic [1:0] h, output logic [7:0] st, output logic [1:0] hd);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_clear = clr; cmd_dry = dry; cmd_addr = a;
    cmd_bound = b; cmd_kind = k; cmd_cond = c; cmd_handle = h;
    @(posedge clk); #1;
    check("R6 rsp_valid after command", {31'd0, rsp_valid}, 32'd1);
    st = rsp_status; hd = rsp_handle;
    cmd_valid = 1'b0;
  endtask

  task automatic set_bp(input logic [31:0] a, input logic [31:0] b, input logic [3:0] k,
                        input logic c, output logic [7:0] st, output logic [1:0] hd);
    cmd(1'b0, 1'b0, a, b, k, c, 2'd0, st, hd);
  endtask

  task automatic clr_bp(input logic [1:0] h, output logic [7:0] st);
    logic [1:0] hd;
    cmd(1'b1, 1'b0, 32'd0, 32'd0, 4'd0, 1'b0, h, st, hd);
  endtask

  task automatic probe(input logic [31:0] pc, input logic exe,
                       output logic hr, output logic [1:0] hh);
    @(negedge clk);
    ins_valid = 1'b1; ins_pc = pc; ins_executed = exe;
    @(posedge clk); #1;
    hr = halt_req; hh = halt_handle;
    ins_valid = 1'b0;
  endtask

  function automatic logic model_hit(input logic [3:0] k, input logic [31:0] lo,
                                     input logic [31:0] hi, input logic [31:0] pc);
    case (k)
      4'd0: return pc == lo;
      4'd1: return pc > lo;
      4'd2: return pc >= lo;
      4'd3: return pc < lo;
      4'd4: return pc <= lo;
      4'd5: return (pc >= lo) && (pc <= hi);
      4'd6: return !((pc >= lo) && (pc <= hi));
      4'd7: return (pc & hi) == lo;
      default: return 1'b0;
    endcase
  endfunction

  task automatic t_reset();
    check("R12 rsp_valid after reset", {31'd0, rsp_valid}, 32'd0);
    check("R12 halt_req after reset", {31'd0, halt_req}, 32'd0);
    @(negedge clk);
    ins_valid = 1'b1; ins_pc = 32'd0; ins_executed = 1'b1;
    @(posedge clk); #1;
    check("R12 no halt with empty bank", {31'd0, halt_req}, 32'd0);
    ins_valid = 1'b0;
  endtask

  task automatic run_kind(input string tag, input logic [3:0] k, input logic [31:0] lo,
                          input logic [31:0] hi, input logic [31:0] pcs[5]);
    logic [7:0] st; logic [1:0] hd; logic hr; logic [1:0] hh;
    set_bp(lo, hi, k, 1'b0, st, hd);
    check({tag, " set status"}, {24'd0, st}, 32'd0);
    check({tag, " set handle"}, {30'd0, hd}, 32'd0);
    for (int i = 0; i < 5; i++) begin
      probe(pcs[i], 1'b1, hr, hh);
      check({tag, " halt"}, {31'd0, hr}, {31'd0, model_hit(k, lo, hi, pcs[i])});
    end
    clr_bp(2'd0, st);
    check({tag, " clear"}, {24'd0, st}, 32'd0);
  endtask

  task automatic t_relational();   // R1
    logic [31:0] pcs[5];
    pcs = '{32'h0FFF, 32'h1000, 32'h1001, 32'hFFFF_FFFF, 32'h0};
    for (int k = 0; k < 5; k++) run_kind("R1 relational kind", 4'(k), 32'h1000, 32'h0, pcs);
  endtask

  task automatic t_range();        // R2
    logic [31:0] pcs[5];
    pcs = '{32'h00FF, 32'h0100, 32'h01FF, 32'h0200, 32'h0150};
    run_kind("R2 in-range", 4'd5, 32'h100, 32'h1FF, pcs);
    run_kind("R2 out-of-range", 4'd6, 32'h100, 32'h1FF, pcs);
  endtask

  task automatic t_mask();         // R3
    logic [31:0] pcs[5];
    pcs = '{32'h1234, 32'h1244, 32'h0030, 32'hFFFF_FF3F, 32'h0};
    run_kind("R3 masked", 4'd7, 32'h30, 32'hF0, pcs);
  endtask

  task automatic t_undef_kind();   // R4
    logic [31:0] pcs[5];
    pcs = '{32'h2000, 32'h0, 32'hFFFF_FFFF, 32'h1FFF, 32'h2001};
    run_kind("R4 kind 8", 4'd8, 32'h2000, 32'hFFFF_FFFF, pcs);
    run_kind("R4 kind 15", 4'd15, 32'h2000, 32'hFFFF_FFFF, pcs);
  endtask

  task automatic t_cond();         // R5
    logic [7:0] st; logic [1:0] hd; logic hr; logic [1:0] hh;
    set_bp(32'h400, 32'h0, 4'd0, 1'b1, st, hd);
    probe(32'h400, 1'b0, hr, hh);
    check("R5 conditional skipped no halt", {31'd0, hr}, 32'd0);
    probe(32'h400, 1'b1, hr, hh);
    check("R5 conditional executed halt", {31'd0, hr}, 32'd1);
    clr_bp(hd, st);
    set_bp(32'h400, 32'h0, 4'd0, 1'b0, st, hd);
    probe(32'h400, 1'b0, hr, hh);
    check("R5 unconditional skipped halt", {31'd0, hr}, 32'd1);
    clr_bp(hd, st);
  endtask

  task automatic t_fill();         // R6 R7 R8 R10
    logic [7:0] st; logic [1:0] hd; logic hr; logic [1:0] hh;
    for (int i = 0; i < 4; i++) begin
      set_bp(32'h5000 + 32'(i * 16), 32'h0, 4'd0, 1'b0, st, hd);
      check("R6 fill handle", {30'd0, hd}, 32'(i));
      check("R7 fill status", {24'd0, st}, (i == 3) ? 32'd142 : 32'd0);
    end
    probe(32'h5030, 1'b1, hr, hh);
    check("R7 last-slot breakpoint installed", {31'd0, hr}, 32'd1);
    check("R7 last-slot handle", {30'd0, hh}, 32'd3);
    set_bp(32'h6000, 32'h0, 4'd0, 1'b0, st, hd);
    check("R7 full bank status", {24'd0, st}, 32'd142);
    check("R7 full bank handle", {30'd0, hd}, 32'd0);
    probe(32'h6000, 1'b1, hr, hh);
    check("R7 rejected set not installed", {31'd0, hr}, 32'd0);
    cmd(1'b0, 1'b1, 32'h6000, 32'h0, 4'd0, 1'b0, 2'd0, st, hd);
    check("R8 dry run on full bank", {24'd0, st}, 32'd142);
    clr_bp(2'd2, st);
    check("R10 clear live handle", {24'd0, st}, 32'd0);
    probe(32'h5020, 1'b1, hr, hh);
    check("R10 cleared slot no halt", {31'd0, hr}, 32'd0);
    cmd(1'b0, 1'b1, 32'h6000, 32'h0, 4'd0, 1'b0, 2'd0, st, hd);
    check("R8 dry run status", {24'd0, st}, 32'd0);
    check("R8 dry run handle", {30'd0, hd}, 32'd2);
    probe(32'h6000, 1'b1, hr, hh);
    check("R8 dry run installs nothing", {31'd0, hr}, 32'd0);
    clr_bp(2'd2, st);
    check("R10 clear free handle", {24'd0, st}, 32'd145);
    for (int i = 0; i < 4; i++) if (i != 2) clr_bp(2'(i), st);
  endtask

  task automatic t_replace();      // R9
    logic [7:0] st; logic [1:0] hd; logic hr; logic [1:0] hh;
    set_bp(32'h7000, 32'h0, 4'd0, 1'b0, st, hd);
    set_bp(32'h7000, 32'h0, 4'd0, 1'b1, st, hd);
    check("R9 replace handle", {30'd0, hd}, 32'd0);
    check("R9 replace status", {24'd0, st}, 32'd0);
    probe(32'h7000, 1'b0, hr, hh);
    check("R9 new flag in effect", {31'd0, hr}, 32'd0);
    for (int i = 1; i < 4; i++) begin
      set_bp(32'h7100 + 32'(i), 32'h0, 4'd0, 1'b0, st, hd);
      check("R9 replace used one slot", {30'd0, hd}, 32'(i));
    end
    check("R9 bank full after three more", {24'd0, st}, 32'd142);
    for (int i = 0; i < 4; i++) clr_bp(2'(i), st);
  endtask

  task automatic t_priority();     // R11
    logic [7:0] st; logic [1:0] hd; logic hr; logic [1:0] hh;
    set_bp(32'h10, 32'h0, 4'd2, 1'b0, st, hd);
    set_bp(32'h20, 32'h0, 4'd0, 1'b0, st, hd);
    probe(32'h20, 1'b1, hr, hh);
    check("R11 two matches halt", {31'd0, hr}, 32'd1);
    check("R11 lowest handle wins", {30'd0, hh}, 32'd0);
    clr_bp(2'd0, st);
    probe(32'h20, 1'b1, hr, hh);
    check("R11 remaining match handle", {30'd0, hh}, 32'd1);
    @(negedge clk); ins_pc = 32'h20; ins_valid = 1'b0;
    @(posedge clk); #1;
    check("R11 no halt without ins_valid", {31'd0, halt_req}, 32'd0);
    clr_bp(2'd1, st);
  endtask

  initial begin
    #(200000 * 5);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_clear = 1'b0; cmd_dry = 1'b0;
    cmd_addr = '0; cmd_bound = '0; cmd_kind = '0; cmd_cond = 1'b0; cmd_handle = '0;
    ins_valid = 1'b0; ins_pc = '0; ins_executed = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    t_reset();
    t_relational();
    t_range();
    t_mask();
    t_undef_kind();
    t_cond();
    t_fill();
    t_replace();
    t_priority();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule